// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM core

This block is a single-data-rate synchronous static memory in which the spacing between a command and its data word is the same for reads and for writes. A command (chip enable, read/write select, address) is sampled on every rising clock edge. The data word that belongs to it occupies the data slot that comes `LATENCY` edges later. A read presents its word in that slot. A write has its word sampled at the edge that ends that slot. Because both directions use the same slot, reads and writes may follow each other in any order on consecutive cycles, and no bus-turnaround cycle is ever needed.

`LATENCY` = 1 gives a flow-through part. The read word is driven combinationally during the cycle after the command edge. `LATENCY` = 2 gives a pipelined part, with a registered read output one cycle later. In pipelined mode the pipeline fill costs one cycle only for the first command after an idle period.

A write whose data has been captured waits in a two-entry pending-write queue. It is written into the array only when a later write pushes it out. Every read compares its address with the write whose data is arriving in the same cycle, then with both queue entries (youngest first), and only then with the array. As a result a read always returns the newest data written to its address. An optional wrapping two-bit burst sequencer can produce successive addresses.

Top module: `zt_sram`

## Requirements
- R1: At each rising edge with `cen`=1, `wr`=1 starts a write and `wr`=0 starts a read. With `cen`=0 the cycle is a deselect. A deselect raises no `rvalid`, writes nothing, and the `wdata` in its slot has no effect.
- R2: With `LATENCY`=1, the word for a read sampled at edge k is driven on `rdata` during the cycle that follows edge k. The data for a write sampled at edge k is taken from `wdata` at edge k+1.
- R3: With `LATENCY`=2, the word for a read sampled at edge k is driven on `rdata` from edge k+1 to edge k+2. The data for a write sampled at edge k is taken from `wdata` at edge k+2.
- R4: Reads and writes can be issued on consecutive cycles in any order with no idle cycle, including a read that directly follows a write.
- R5: A read returns the data of the most recent earlier write to its address. This holds even when that data is still pending, and even when it arrives in the same cycle as the read lookup.
- R6: When both pending-queue entries hold the read address, the read returns the younger of the two.
- R7: `rvalid` is 1 exactly in the cycles in which a read word is presented, and 0 in all other cycles.
- R8: While `rvalid` is 0, `rdata` keeps the last word that was presented (0 after reset).
- R9: Burst sequencing works as follows. A cycle with `cen`=1 opens a burst, and a cycle with `cen`=0 closes it. When `adv`=1 with `cen`=1 while a burst is open, the address is the previous command's address with its two low bits incremented modulo 4 and its upper bits kept, and the `addr` input is ignored. When `adv`=1 while no burst is open, `addr` is used.
- R10: An active-low asynchronous reset clears `rvalid` and `rdata` to 0, discards pending writes and in-flight commands, and closes any burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen | input | 1 | Chip enable; 1 accepts a command this edge |
| wr | input | 1 | 1 = write, 0 = read |
| adv | input | 1 | Advance burst address instead of using `addr` |
| addr | input | ADDR_W | Command address |
| wdata | input | DATA_W | Write word, sampled LATENCY edges after its command |
| rdata | output | DATA_W | Read word, held between reads |
| rvalid | output | 1 | High in the cycle a read word is presented |

## Verification
The hardest state to reach from the ports is the one where both queue entries hold the same address, so that the youngest-match rule actually decides the result. The stimulus writes one address on two consecutive cycles and then leaves an idle slot, so that neither write is still in flight when the read looks it up. The same-cycle forwarding path (a read directly after a write to the same address) and a burst that wraps past the fourth word are driven into a flow-through instance and a pipelined instance at the same time, each with its own data slot timing. A reset asserted while a read is in flight then shows that the word is dropped.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Kind of transaction carried by a command stage
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_e;

    // Burst address sequencer state
    typedef enum logic {
        SEQ_CLOSED = 1'b0,
        SEQ_OPEN   = 1'b1
    } seq_state_e;

endpackage

// File: rtl/zt_sram_seq.sv
module zt_sram_seq
    import zt_sram_pkg::*;
#(
    parameter int AW       = 6,
    parameter int BURST_EN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen,
    input  logic          adv,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cmd_addr,
    output logic          burst_open
);

    generate
        if (BURST_EN != 0) begin : g_burst
            seq_state_e    state_q, state_d;
            logic [AW-1:0] last_q;

            // state register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= SEQ_CLOSED;
                    last_q  <= '0;
                end else begin
                    state_q <= state_d;
                    if (cen) last_q <= cmd_addr;
                end
            end

            // transitions: any accepted command opens, a deselect closes
            always_comb begin
                unique case (state_q)
                    SEQ_CLOSED: state_d = cen ? SEQ_OPEN : SEQ_CLOSED;
                    SEQ_OPEN:   state_d = cen ? SEQ_OPEN : SEQ_CLOSED;
                    default:    state_d = SEQ_CLOSED;
                endcase
            end

            // outputs: wrapping increment of the low two bits
            always_comb begin
                unique case (state_q)
                    SEQ_CLOSED: cmd_addr = addr;
                    SEQ_OPEN:   cmd_addr = adv ? {last_q[AW-1:2], last_q[1:0] + 2'd1}
                                               : addr;
                    default:    cmd_addr = addr;
                endcase
            end

            assign burst_open = (state_q == SEQ_OPEN);
        end else begin : g_flat
            assign cmd_addr   = addr;
            assign burst_open = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
    import zt_sram_pkg::*;
#(
    parameter int AW      = 6,
    parameter int LATENCY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen,
    input  logic          wr,
    input  logic [AW-1:0] cmd_addr,
    output slot_e         look_kind,
    output logic [AW-1:0] look_addr,
    output slot_e         data_kind,
    output logic [AW-1:0] data_addr
);

    slot_e         s1_kind, s1_kind_d;
    logic [AW-1:0] s1_addr;

    always_comb begin
        unique case ({cen, wr})
            2'b10:   s1_kind_d = SLOT_READ;
            2'b11:   s1_kind_d = SLOT_WRITE;
            default: s1_kind_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_kind <= SLOT_IDLE;
            s1_addr <= '0;
        end else begin
            s1_kind <= s1_kind_d;
            s1_addr <= cmd_addr;
        end
    end

    assign look_kind = s1_kind;
    assign look_addr = s1_addr;

    generate
        if (LATENCY == 1) begin : g_ft
            assign data_kind = s1_kind;
            assign data_addr = s1_addr;
        end else begin : g_pl
            slot_e         s2_kind;
            logic [AW-1:0] s2_addr;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s2_kind <= SLOT_IDLE;
                    s2_addr <= '0;
                end else begin
                    s2_kind <= s1_kind;
                    s2_addr <= s1_addr;
                end
            end
            assign data_kind = s2_kind;
            assign data_addr = s2_addr;
        end
    endgenerate

endmodule

// File: rtl/zt_sram_store.sv
module zt_sram_store
    import zt_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         data_kind,
    input  logic [AW-1:0] data_addr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] look_addr,
    output logic [DW-1:0] look_data
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } pend_t;

    logic [DW-1:0] mem [DEPTH];
    pend_t         q_young, q_old;
    logic          push;

    assign push = (data_kind == SLOT_WRITE);

    // two-entry pending queue; the older entry retires when a new word arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_young <= '0;
            q_old   <= '0;
        end else if (push) begin
            q_old   <= q_young;
            q_young <= '{vld: 1'b1, addr: data_addr, data: wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (push && q_old.vld) mem[q_old.addr] <= q_old.data;
    end

    // snoop order: arriving word, youngest pending, older pending, array
    always_comb begin
        if (push && (data_addr == look_addr))
            look_data = wdata;
        else if (q_young.vld && (q_young.addr == look_addr))
            look_data = q_young.data;
        else if (q_old.vld && (q_old.addr == look_addr))
            look_data = q_old.data;
        else
            look_data = mem[look_addr];
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int LATENCY  = 2,
    parameter int BURST_EN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen,
    input  logic              wr,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [ADDR_W-1:0] cmd_addr;
    logic              burst_open;
    slot_e             look_kind, data_kind;
    logic [ADDR_W-1:0] look_addr, data_addr;
    logic [DATA_W-1:0] look_data;
    logic              read_now;

    zt_sram_seq #(.AW(ADDR_W), .BURST_EN(BURST_EN)) u_seq (
        .clk(clk), .rst_n(rst_n), .cen(cen), .adv(adv), .addr(addr),
        .cmd_addr(cmd_addr), .burst_open(burst_open)
    );

    zt_sram_pipe #(.AW(ADDR_W), .LATENCY(LATENCY)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cen(cen), .wr(wr), .cmd_addr(cmd_addr),
        .look_kind(look_kind), .look_addr(look_addr),
        .data_kind(data_kind), .data_addr(data_addr)
    );

    zt_sram_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .data_kind(data_kind), .data_addr(data_addr),
        .wdata(wdata), .look_addr(look_addr), .look_data(look_data)
    );

    assign read_now = (look_kind == SLOT_READ);

    generate
        if (LATENCY == 1) begin : g_out_ft
            logic [DATA_W-1:0] hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hold_q <= '0;
                else if (read_now) hold_q <= look_data;
            end
            assign rvalid = read_now;
            assign rdata  = read_now ? look_data : hold_q;
        end else begin : g_out_pl
            logic              vld_q;
            logic [DATA_W-1:0] data_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q  <= 1'b0;
                    data_q <= '0;
                end else begin
                    vld_q <= read_now;
                    if (read_now) data_q <= look_data;
                end
            end
            assign rvalid = vld_q;
            assign rdata  = data_q;
        end
    endgenerate

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int AW       = 6,
    parameter int DW       = 16,
    parameter int LATENCY  = 2,
    parameter int BURST_EN = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cen,
    input logic          wr,
    input logic          adv,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input logic          burst_open,
    input logic [AW-1:0] s1_addr
);

    // R8: output word is held while no read is presented
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !rvalid) |-> $stable(rdata));

    generate
        if (LATENCY == 1) begin : g_ft
            // R7 / R2: valid exactly one cycle after a read command
            a_r7_valid_exact: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (rvalid == $past(cen && !wr)));
            // R5: read right after a write to the same address sees the new word
            a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2) &&
                 $past(cen && !wr && !adv) && $past(cen && wr && !adv, 2) &&
                 ($past(addr) == $past(addr, 2)))
                |-> (rdata == $past(wdata)));
        end else begin : g_pl
            // R7 / R3: valid exactly two cycles after a read command
            a_r7_valid_exact: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (rvalid == $past(cen && !wr, 2)));
            // R5: read right after a write to the same address sees the new word
            a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) &&
                 $past(cen && !wr && !adv, 2) && $past(cen && wr && !adv, 3) &&
                 ($past(addr, 2) == $past(addr, 3)))
                |-> (rdata == $past(wdata)));
        end

        if (BURST_EN != 0) begin : g_burst
            // R9: advance keeps the upper bits and steps the low two bits
            a_r9_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
                (cen && adv && burst_open) |=>
                (s1_addr == {$past(s1_addr[AW-1:2]), $past(s1_addr[1:0]) + 2'd1}));
        end
    endgenerate

endmodule

bind zt_sram zt_sram_chk #(
    .AW(ADDR_W), .DW(DATA_W), .LATENCY(LATENCY), .BURST_EN(BURST_EN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cen(cen), .wr(wr), .adv(adv), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .burst_open(burst_open), .s1_addr(look_addr)
);

// File: tb/zt_sram_bench.sv
module zt_sram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 25;

    typedef struct packed {
        logic        cen;
        logic        wr;
        logic        adv;
        logic [5:0]  addr;
        logic [15:0] wd;
        logic        ev;
        logic [15:0] ed;
    } vec_t;

    // R4: back-to-back mixed commands; R6 at step 9; R9 burst at 16..24
    localparam vec_t VEC [N] = '{
        '{1'b1, 1'b1, 1'b0, 6'd5,  16'h1111, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 6'd5,  16'h0000, 1'b1, 16'h1111},
        '{1'b1, 1'b1, 1'b0, 6'd5,  16'h2222, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 6'd5,  16'h3333, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 6'd5,  16'h0000, 1'b1, 16'h3333},
        '{1'b0, 1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 6'd9,  16'hA0A0, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 6'd9,  16'hB0B0, 1'b0, 16'h0000},
        '{1'b0, 1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 6'd9,  16'h0000, 1'b1, 16'hB0B0},
        '{1'b1, 1'b0, 1'b0, 6'd5,  16'h0000, 1'b1, 16'h3333},
        '{1'b1, 1'b1, 1'b0, 6'd20, 16'hC3C3, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 6'd20, 16'h0000, 1'b1, 16'hC3C3},
        '{1'b1, 1'b0, 1'b0, 6'd9,  16'h0000, 1'b1, 16'hB0B0},
        '{1'b1, 1'b1, 1'b0, 6'd9,  16'h0101, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 6'd9,  16'h0000, 1'b1, 16'h0101},
        '{1'b1, 1'b1, 1'b0, 6'd32, 16'h1000, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b1, 6'd7,  16'h1001, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b1, 6'd7,  16'h1002, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b1, 6'd7,  16'h1003, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b1, 6'd7,  16'h0000, 1'b1, 16'h1000},
        '{1'b0, 1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b1, 6'd35, 16'h0000, 1'b1, 16'h1003},
        '{1'b1, 1'b0, 1'b1, 6'd7,  16'h0000, 1'b1, 16'h1000},
        '{1'b1, 1'b0, 1'b0, 6'd34, 16'h0000, 1'b1, 16'h1002}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cen = 1'b0, wr = 1'b0, adv = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wd_pl = '0, wd_ft = '0;
    logic [15:0] rd_pl, rd_ft;
    logic        rv_pl, rv_ft;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zt_sram #(.ADDR_W(6), .DATA_W(16), .LATENCY(2), .BURST_EN(1)) u_zt_sram (
        .clk(clk), .rst_n(rst_n), .cen(cen), .wr(wr), .adv(adv), .addr(addr),
        .wdata(wd_pl), .rdata(rd_pl), .rvalid(rv_pl)
    );

    zt_sram #(.ADDR_W(6), .DATA_W(16), .LATENCY(1), .BURST_EN(1)) u_zt_sram_ft (
        .clk(clk), .rst_n(rst_n), .cen(cen), .wr(wr), .adv(adv), .addr(addr),
        .wdata(wd_ft), .rdata(rd_ft), .rvalid(rv_ft)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic string tag_of(input int j);
        if (j == 9) return "R6";
        if (j >= 16) return "R9";
        if (j >= 1 && j <= 4) return "R4";
        if (VEC[j].ev) return "R5";
        return "R7";
    endfunction

    task automatic slot_check(input string lbl, input int j, input logic v,
                              input logic [15:0] d, input logic [15:0] last);
        check($sformatf("%s %s step %0d rvalid", lbl, tag_of(j), j), {31'd0, v}, {31'd0, VEC[j].ev});
        if (VEC[j].ev)
            check($sformatf("%s %s step %0d rdata", lbl, tag_of(j), j), {16'd0, d}, {16'd0, VEC[j].ed});
        else
            check($sformatf("%s R8 step %0d hold", lbl, j), {16'd0, d}, {16'd0, last});
    endtask

    task automatic drive(input logic c, input logic w, input logic a, input logic [5:0] ad);
        cen = c; wr = w; adv = a; addr = ad;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] last_pl = '0;
        logic [15:0] last_ft = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 pl rvalid after reset", {31'd0, rv_pl}, 32'd0);
        check("R10 pl rdata after reset", {16'd0, rd_pl}, 32'd0);
        check("R10 ft rvalid after reset", {31'd0, rv_ft}, 32'd0);
        check("R10 ft rdata after reset", {16'd0, rd_ft}, 32'd0);

        // table walk: step i issues VEC[i]; slots of VEC[i-L] are checked and fed
        for (int i = 0; i < N + 2; i++) begin
            if (i >= 1 && i - 1 < N) begin
                slot_check("R2 ft", i - 1, rv_ft, rd_ft, last_ft);
                if (VEC[i-1].ev) last_ft = VEC[i-1].ed;
            end
            if (i >= 2 && i - 2 < N) begin
                slot_check("R3 pl", i - 2, rv_pl, rd_pl, last_pl);
                if (VEC[i-2].ev) last_pl = VEC[i-2].ed;
            end
            if (i < N) drive(VEC[i].cen, VEC[i].wr, VEC[i].adv, VEC[i].addr);
            else       drive(1'b0, 1'b0, 1'b0, 6'd0);
            wd_ft = (i >= 1 && i - 1 < N) ? VEC[i-1].wd : 16'h0000;
            wd_pl = (i >= 2 && i - 2 < N) ? VEC[i-2].wd : 16'h0000;
            @(negedge clk);
        end

        // R1: deselect with write select and garbage data changes nothing
        drive(1'b0, 1'b1, 1'b0, 6'd20); wd_ft = 16'hFFFF; wd_pl = 16'hFFFF;
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 6'd0);
        check("R1 ft no rvalid on deselect", {31'd0, rv_ft}, 32'd0);
        @(negedge clk);
        check("R1 pl no rvalid on deselect", {31'd0, rv_pl}, 32'd0);
        drive(1'b1, 1'b0, 1'b0, 6'd20);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 6'd0);
        check("R1 ft rvalid", {31'd0, rv_ft}, 32'd1);
        check("R1 ft data unchanged", {16'd0, rd_ft}, 32'h0000C3C3);
        @(negedge clk);
        check("R1 pl rvalid", {31'd0, rv_pl}, 32'd1);
        check("R1 pl data unchanged", {16'd0, rd_pl}, 32'h0000C3C3);
        check("R8 ft hold after read", {16'd0, rd_ft}, 32'h0000C3C3);
        check("R7 ft idle slot", {31'd0, rv_ft}, 32'd0);
        wd_ft = '0; wd_pl = '0;

        // R10: reset while a read is in flight drops it
        drive(1'b1, 1'b0, 1'b0, 6'd5);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 6'd0);
        rst_n = 1'b0;
        #1;
        check("R10 ft rvalid dropped", {31'd0, rv_ft}, 32'd0);
        check("R10 ft rdata cleared", {16'd0, rd_ft}, 32'd0);
        @(negedge clk);
        check("R10 pl rvalid dropped", {31'd0, rv_pl}, 32'd0);
        check("R10 pl rdata cleared", {16'd0, rd_pl}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // write then read back-to-back after reset
        drive(1'b1, 1'b1, 1'b0, 6'd50);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 6'd50); wd_ft = 16'h5A5A;
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 6'd0); wd_ft = '0; wd_pl = 16'h5A5A;
        check("R5 ft after reset rvalid", {31'd0, rv_ft}, 32'd1);
        check("R5 ft after reset rdata", {16'd0, rd_ft}, 32'h00005A5A);
        @(negedge clk);
        wd_pl = '0;
        check("R5 pl after reset rvalid", {31'd0, rv_pl}, 32'd1);
        check("R5 pl after reset rdata", {16'd0, rd_pl}, 32'h00005A5A);
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule